// File: doc/BRIEF.md
# Cycle-Shared Single-Port FIFO

This block is a synchronous first-in first-out buffer that keeps its words in a memory array with only one port. A second clock runs at twice the system rate with its rising edges aligned to the system clock. In every system period the first double-rate edge reads the word at the head of the queue, and the edge that coincides with the next system edge writes the incoming word. One address and data path therefore serves both directions.

Pointers, the occupancy counter and all flags live in the system clock domain. The caller presents a word with a write request, or raises a read request, and sees the result at the next system edge. A read request is honoured only while at least one word is stored. A write request is honoured only while at least one slot is free. A synchronous clear empties the queue. A programmable level drives a flag that is high while the occupancy is strictly above that level.

Top module: `cs_fifo`

## Requirements
- R1: Words that are accepted by write requests leave through accepted read requests in the order they were written, with no loss and no duplication.
- R2: A read request while `empty` is 1 is ignored. `used`, `empty` and `rd_data` keep their values.
- R3: A write request while `full` is 1 is ignored. The count stays at DEPTH and the stored words are unchanged, which shows when the queue is drained.
- R4: A clear sampled at a system edge leaves the queue empty after that edge (`empty`=1, `used`=0, `full`=0). It wins over any read or write request in the same cycle.
- R5: `used` is $clog2(DEPTH) bits wide. `full` is 1 exactly when the occupancy equals DEPTH. For a power-of-two depth, {`full`,`used`} is the occupancy. `empty` is 1 exactly when the occupancy is zero.
- R6: `above_level` is 1 exactly when the occupancy is strictly greater than the unsigned value on `level`.
- R7: When a read and a write are both accepted in one system cycle, the occupancy is unchanged and the written word joins the tail of the queue.
- R8: `rd_data` is registered. It takes the head word at the system edge that accepts a read and holds its value in all other cycles. Its power-up value is zero.
- R9: `clk2x` has twice the frequency of `clk`, with rising edges aligned. The memory port alternates: a read on the edge in the middle of each system period, and a write on the edge aligned with the system edge. A word written in one cycle can be read in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| clk2x | input | 1 | Double-rate clock, rising edges aligned with clk |
| clear | input | 1 | Synchronous clear to empty |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| level | input | $clog2(DEPTH) | Threshold level for above_level |
| rd_data | output | WIDTH | Registered read word |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| used | output | $clog2(DEPTH) | Occupancy, low bits |
| above_level | output | 1 | Occupancy greater than level |

## Verification
The assertions assume that `clk2x` runs at exactly twice the rate of `clk`, with every rising edge of `clk` landing on a rising edge of `clk2x`. They also assume that requests and data change only between edges. The bench produces both clocks from one loop, so the alignment always holds. It drives inputs shortly after each system edge, so they are stable at both double-rate edges that follow. Because of this, the phase-alternation property and the hold properties for reads while empty and writes while full see only legal stimulus.

// File: rtl/cs_fifo.sv
module cs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     clk2x,
  input  logic                     clear,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] level,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH)-1:0] used,
  output logic                     above_level
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr = '0;
  logic [AW-1:0]    rd_ptr = '0;
  logic [AW:0]      cnt = '0;
  logic             tog = 1'b0;
  logic             seen = 1'b0;
  logic [WIDTH-1:0] head_q = '0;
  logic [WIDTH-1:0] rd_q = '0;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire rd_acc = rd_en && !empty && !clear;
  wire wr_acc = wr_en && !full && !clear;

  // phase: tog flips on each system edge, seen trails it on double-rate edges
  always_ff @(posedge clk) tog <= ~tog;
  always_ff @(posedge clk2x) seen <= tog;
  wire rd_phase = tog ^ seen;
  wire [AW-1:0] port_addr = rd_phase ? rd_ptr : wr_ptr;

  always_ff @(posedge clk2x) begin
    if (rd_phase)
      head_q <= mem[port_addr];
    else if (wr_acc)
      mem[port_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_acc) wr_ptr <= bump(wr_ptr);
      if (rd_acc) rd_ptr <= bump(rd_ptr);
      if (wr_acc && !rd_acc)      cnt <= cnt + 1'b1;
      else if (rd_acc && !wr_acc) cnt <= cnt - 1'b1;
    end
    if (rd_acc) rd_q <= head_q;
  end

  assign rd_data     = rd_q;
  assign empty       = (cnt == '0);
  assign full        = (cnt == (AW+1)'(DEPTH));
  assign used        = cnt[AW-1:0];
  assign above_level = (cnt > {1'b0, level});

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (clear) cnt <= (AW+1)'(DEPTH)); // R5
  AST_CLEAR_EMPTY: assert property (@(posedge clk) clear |=> (empty && !full && used == '0)); // R4
  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (clear)
    (empty && rd_en && !wr_en) |=> (empty && $stable(rd_data))); // R2
  AST_FULL_WRITE_HOLD: assert property (@(posedge clk) disable iff (clear)
    (full && wr_en && !rd_en) |=> full); // R3
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (clear)
    (!empty && !full && rd_en && wr_en) |=> ($stable(used) && !empty)); // R7
  AST_ABOVE_NOT_EMPTY: assert property (@(posedge clk) disable iff (clear)
    above_level |-> !empty); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (clear)
    !(rd_en && !empty) |=> $stable(rd_data)); // R8
  AST_PHASE_ALT: assert property (@(posedge clk2x) disable iff (clear)
    rd_phase |=> !rd_phase); // R9
  AST_PHASE_BACK: assert property (@(posedge clk2x) disable iff (clear)
    !rd_phase |=> rd_phase); // R9
endmodule

// File: tb/tb_cs_fifo.sv
`timescale 1ns/1ps
module tb_cs_fifo;
  localparam int CLK_PERIOD = 20;
  localparam int W = 8;
  localparam int D = 8;
  localparam int AW = $clog2(D);

  logic clk = 0, clk2x = 0, clear = 0, wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [AW-1:0] level = '0;
  logic [W-1:0] rd_data;
  logic empty, full, above_level;
  logic [AW-1:0] used;

  int checks = 0, errors = 0;
  logic [W-1:0] q [$];
  logic [W-1:0] mrd = '0;
  bit done = 0;

  cs_fifo #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .clk2x(clk2x), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .level(level), .rd_data(rd_data), .empty(empty), .full(full),
    .used(used), .above_level(above_level));

  initial forever begin
    #(CLK_PERIOD/4) clk2x = 1; clk = ~clk;
    #(CLK_PERIOD/4) clk2x = 0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic r, input logic [W-1:0] d);
    bit rok, wok;
    clear = c; wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    if (c) q.delete();
    else begin
      rok = r && q.size() > 0;
      wok = w && q.size() < D;
      if (rok) mrd = q.pop_front();
      if (wok) q.push_back(d);
    end
    #1;
    chk(rd_data === mrd, "R1/R8 rd_data", int'(rd_data), int'(mrd));
    chk(empty === (q.size() == 0), "R5 empty", int'(empty), int'(q.size() == 0));
    chk(full === (q.size() == D), "R5 full", int'(full), int'(q.size() == D));
    chk(used === AW'(q.size()), "R5 used", int'(used), q.size() % D);
    chk(above_level === (q.size() > int'(level)), "R6 above_level",
        int'(above_level), int'(q.size() > int'(level)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold;
    level = AW'(3);
    cyc(1, 0, 0, 0);
    chk(empty === 1'b1 && used === '0, "R4 reset state", int'(used), 0);
    // R2: read while empty
    hold = rd_data;
    cyc(0, 0, 1, 0);
    chk(rd_data === hold && empty === 1'b1, "R2 empty read ignored", int'(rd_data), int'(hold));
    // R1/R9: fill to full, data written every cycle
    for (int i = 0; i < D; i++) cyc(0, 1, 0, W'(8'hA0 + i));
    chk(full === 1'b1, "R5 full after DEPTH writes", int'(full), 1);
    // R3: write while full
    cyc(0, 1, 0, W'(8'h5A));
    chk(full === 1'b1 && used === '0, "R3 full write ignored", int'(used), 0);
    // R6: sweep levels while draining
    for (int i = 0; i < D; i++) begin
      level = AW'(i);
      cyc(0, 0, 1, 0);
      chk(rd_data === W'(8'hA0 + i), "R3 drained word intact", int'(rd_data), 8'hA0 + i);
    end
    cyc(0, 0, 1, 0);
    chk(empty === 1'b1, "R2 read past empty", int'(empty), 1);
    // R9: write then read on the next cycle, streaming
    for (int i = 0; i < 12; i++) cyc(0, i % 2 == 0, i % 2 == 1, W'(8'h30 + i));
    // R7: simultaneous read and write at mid fill
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, W'(8'h60 + i));
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, 1, W'(8'h70 + i));
      chk(used === AW'(4), "R7 both accepted count kept", int'(used), 4);
    end
    // R4: clear wins over requests
    cyc(1, 1, 1, W'(8'hEE));
    chk(empty === 1'b1 && used === '0, "R4 clear priority", int'(used), 0);
    // R9: write while empty and read in the next cycle
    cyc(0, 1, 0, W'(8'h11));
    cyc(0, 1, 1, W'(8'h22));
    chk(rd_data === W'(8'h11), "R9 write-then-read", int'(rd_data), 8'h11);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      level = AW'($urandom_range(0, D - 1));
      cyc(($urandom_range(0, 49) == 0), $urandom_range(0, 1) == 1,
          $urandom_range(0, 1) == 1, W'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule